// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Generation

This block is the arithmetic and logic unit of a small 8-bit processor core. The accumulator is always the first operand. The second operand comes from a math register or another source. A 4-bit operation code picks one of sixteen functions. The block returns a primary result byte and a secondary byte, which is used only by multiply and divide. It also returns four status flags: carry, nibble (auxiliary) carry, signed overflow and parity.

Every result and flag is combinational. The incoming carry, auxiliary-carry and overflow values pass through unchanged for operations that do not define them, so the surrounding core can write all four flags back on every operation. A write-back strobe tells the core whether the primary result should be stored. An optional flag register captures the four flags on a load strobe. The parameter `REG_FLAGS` selects whether that register is built.

Top module: `acc_alu`

## Requirements
- R1: Code 0 gives acc+opnd, and code 1 gives acc+opnd+cyIn. `cyOut` is the carry out of bit 7.
- R2: For codes 0, 1, 2 and 13, `acOut` is set exactly when the low nibble produces a carry (add) or needs a borrow (subtract) into bit 4.
- R3: For codes 0, 1, 2 and 13, `ovOut` is set exactly when the two's-complement result does not fit in 8 signed bits.
- R4: `parOut` is 1 when `resultOut` holds an even number of ones, and 0 when it holds an odd number.
- R5: Code 2 gives acc-opnd-cyIn. `cyOut` is set when a borrow into bit 7 occurs.
- R6: Code 13 (compare) sets the flags as acc-opnd, with no borrow-in, and drives `writeBack` low. Every other code drives `writeBack` high.
- R7: Increment (3), decrement (4), AND (5), OR (6), XOR (7) and complement of acc (8) produce their results, and `cyOut`/`acOut`/`ovOut` equal `cyIn`/`acIn`/`ovIn`.
- R8: Rotate left (9) and rotate right (10) wrap within 8 bits and leave `cyOut` equal to `cyIn`. Codes 11 (left) and 12 (right) rotate through carry as a ninth bit.
- R9: Multiply (14) puts the low byte of acc*opnd in `resultOut` and the high byte in `extraOut`. It clears `cyOut` and sets `ovOut` exactly when the high byte is non-zero.
- R10: Divide (15) puts the quotient in `resultOut` and the remainder in `extraOut`, and clears `cyOut`. With a zero divisor it sets `ovOut` and returns quotient 0xFF with remainder equal to acc.
- R11: `flagQ` is {CY,AC,OV,P} from bit 3 down to bit 0. It clears to zero in reset, loads the current flags on a clock edge with `flagLoad` high, and holds otherwise.
- R12: `extraOut` is zero for every code other than 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Active-low reset of the flag register |
| flagLoad | input | 1 | Capture the current flags into `flagQ` |
| opSel | input | 4 | Operation code |
| accIn | input | 8 | Accumulator operand |
| opndIn | input | 8 | Second operand |
| cyIn | input | 1 | Current carry flag |
| acIn | input | 1 | Current auxiliary carry flag |
| ovIn | input | 1 | Current overflow flag |
| resultOut | output | 8 | Primary result |
| extraOut | output | 8 | Multiply high byte or divide remainder |
| writeBack | output | 1 | Primary result is to be stored |
| cyOut | output | 1 | New carry flag |
| acOut | output | 1 | New auxiliary carry flag |
| ovOut | output | 1 | New overflow flag |
| parOut | output | 1 | Parity of the primary result |
| flagQ | output | 4 | Registered {CY,AC,OV,P} |

## Verification
The vectors cover the cases that separate unsigned carry from signed overflow. One is 0x80+0x80, which sets both flags. Another is 0x7F+0x01, which sets overflow but not carry. A swapped overflow term would misreport one of the two. Nibble borrow cases, such as 0x50-0x20 with borrow-in, catch an auxiliary flag taken from the wrong bit. Compare is run with carry-in set, so a compare that wrongly uses the borrow shows up. It is also checked for a low write-back. Pass-through operations use deliberately mismatched incoming flags, so a stray update is visible. A multiply overflowing into the high byte, a divide with a remainder and a zero-divisor divide each expose a different faulty datapath path.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_RL   = 4'd9,
    OP_RR   = 4'd10,
    OP_RLC  = 4'd11,
    OP_RRC  = 4'd12,
    OP_CMP  = 4'd13,
    OP_MUL  = 4'd14,
    OP_DIV  = 4'd15
  } aluOpT;

  typedef enum logic [2:0] {
    SRC_ADDER = 3'd0,
    SRC_LOGIC = 3'd1,
    SRC_ROT   = 3'd2,
    SRC_MUL   = 3'd3,
    SRC_DIV   = 3'd4
  } srcSelT;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_CPL = 2'd3
  } logicSelT;

  // strobes from decode to datapath
  typedef struct packed {
    srcSelT   src;
    logic     subMode;      // adder subtracts
    logic     carryInUse;   // adder takes cyIn
    logic     unitOperand;  // adder second operand is constant one
    logic     arithFlags;   // adder updates CY/AC/OV
    logicSelT logicSel;
    logic     rotLeft;
    logic     rotThruCy;
    logic     writeBack;
  } aluCtrlT;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrlT    ctrl
);

  always_comb begin
    ctrl = '{src: SRC_ADDER, subMode: 1'b0, carryInUse: 1'b0, unitOperand: 1'b0,
             arithFlags: 1'b0, logicSel: LG_AND, rotLeft: 1'b0, rotThruCy: 1'b0,
             writeBack: 1'b1};
    unique case (aluOpT'(opSel))
      OP_ADD:  ctrl.arithFlags = 1'b1;
      OP_ADDC: begin
        ctrl.arithFlags = 1'b1;
        ctrl.carryInUse = 1'b1;
      end
      OP_SUBB: begin
        ctrl.arithFlags = 1'b1;
        ctrl.carryInUse = 1'b1;
        ctrl.subMode    = 1'b1;
      end
      OP_CMP: begin
        ctrl.arithFlags = 1'b1;
        ctrl.subMode    = 1'b1;
        ctrl.writeBack  = 1'b0;
      end
      OP_INC:  ctrl.unitOperand = 1'b1;
      OP_DEC: begin
        ctrl.unitOperand = 1'b1;
        ctrl.subMode     = 1'b1;
      end
      OP_AND: begin
        ctrl.src      = SRC_LOGIC;
        ctrl.logicSel = LG_AND;
      end
      OP_OR: begin
        ctrl.src      = SRC_LOGIC;
        ctrl.logicSel = LG_OR;
      end
      OP_XOR: begin
        ctrl.src      = SRC_LOGIC;
        ctrl.logicSel = LG_XOR;
      end
      OP_CPL: begin
        ctrl.src      = SRC_LOGIC;
        ctrl.logicSel = LG_CPL;
      end
      OP_RL: begin
        ctrl.src     = SRC_ROT;
        ctrl.rotLeft = 1'b1;
      end
      OP_RR:   ctrl.src = SRC_ROT;
      OP_RLC: begin
        ctrl.src       = SRC_ROT;
        ctrl.rotLeft   = 1'b1;
        ctrl.rotThruCy = 1'b1;
      end
      OP_RRC: begin
        ctrl.src       = SRC_ROT;
        ctrl.rotThruCy = 1'b1;
      end
      OP_MUL:  ctrl.src = SRC_MUL;
      OP_DIV:  ctrl.src = SRC_DIV;
      default: ctrl.src = SRC_ADDER;
    endcase
  end

endmodule

// File: rtl/acc_alu_div.sv
module acc_alu_div #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              divZero
);

  localparam int REM_W = DATA_W + 1;

  logic [REM_W-1:0] partial;

  // restoring division; a zero divisor naturally yields all-ones and rem = dividend
  always_comb begin
    partial  = '0;
    quotient = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      partial = {partial[REM_W-2:0], dividend[i]};
      if (partial >= {1'b0, divisor}) begin
        partial     = partial - {1'b0, divisor};
        quotient[i] = 1'b1;
      end
    end
    remainder = partial[DATA_W-1:0];
    divZero   = (divisor == '0);
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtrlT           ctrl,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opndIn,
  input  logic              cyIn,
  input  logic              acIn,
  input  logic              ovIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] extra,
  output logic              cy,
  output logic              ac,
  output logic              ov,
  output logic              par
);

  localparam int NIB_W  = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] opB;
  logic              cinEff;
  logic [DATA_W:0]   wideSum;
  logic [NIB_W:0]    nibSum;
  logic              addOv;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] rotRes;
  logic              rotCy;
  logic [PROD_W-1:0] product;
  logic [DATA_W-1:0] quot;
  logic [DATA_W-1:0] remd;
  logic              divZero;

  // adder / subtractor shared by add, subtract, compare, inc, dec
  always_comb begin
    opB    = ctrl.unitOperand ? DATA_W'(1) : opndIn;
    cinEff = ctrl.carryInUse & cyIn;
    if (ctrl.subMode) begin
      wideSum = {1'b0, accIn} - {1'b0, opB} - (DATA_W+1)'(cinEff);
      nibSum  = {1'b0, accIn[NIB_W-1:0]} - {1'b0, opB[NIB_W-1:0]} - (NIB_W+1)'(cinEff);
      addOv   = (accIn[MSB] ^ opB[MSB]) & (wideSum[MSB] ^ accIn[MSB]);
    end else begin
      wideSum = {1'b0, accIn} + {1'b0, opB} + (DATA_W+1)'(cinEff);
      nibSum  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, opB[NIB_W-1:0]} + (NIB_W+1)'(cinEff);
      addOv   = ~(accIn[MSB] ^ opB[MSB]) & (wideSum[MSB] ^ accIn[MSB]);
    end
  end

  always_comb begin
    unique case (ctrl.logicSel)
      LG_AND:  logicRes = accIn & opndIn;
      LG_OR:   logicRes = accIn | opndIn;
      LG_XOR:  logicRes = accIn ^ opndIn;
      default: logicRes = ~accIn;
    endcase
  end

  always_comb begin
    if (ctrl.rotLeft) begin
      rotRes = {accIn[MSB-1:0], ctrl.rotThruCy ? cyIn : accIn[MSB]};
      rotCy  = accIn[MSB];
    end else begin
      rotRes = {ctrl.rotThruCy ? cyIn : accIn[0], accIn[MSB:1]};
      rotCy  = accIn[0];
    end
  end

  assign product = {{DATA_W{1'b0}}, accIn} * {{DATA_W{1'b0}}, opndIn};

  acc_alu_div #(.DATA_W(DATA_W)) u_div (
    .dividend (accIn),
    .divisor  (opndIn),
    .quotient (quot),
    .remainder(remd),
    .divZero  (divZero)
  );

  // result and flag selection
  always_comb begin
    result = wideSum[DATA_W-1:0];
    extra  = '0;
    cy     = cyIn;
    ac     = acIn;
    ov     = ovIn;
    unique case (ctrl.src)
      SRC_ADDER: begin
        if (ctrl.arithFlags) begin
          cy = wideSum[DATA_W];
          ac = nibSum[NIB_W];
          ov = addOv;
        end
      end
      SRC_LOGIC: result = logicRes;
      SRC_ROT: begin
        result = rotRes;
        if (ctrl.rotThruCy) cy = rotCy;
      end
      SRC_MUL: begin
        result = product[DATA_W-1:0];
        extra  = product[PROD_W-1:DATA_W];
        cy     = 1'b0;
        ov     = |product[PROD_W-1:DATA_W];
      end
      SRC_DIV: begin
        result = quot;
        extra  = remd;
        cy     = 1'b0;
        ov     = divZero;
      end
      default: result = wideSum[DATA_W-1:0];
    endcase
    par = ~^result;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flagLoad,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opndIn,
  input  logic              cyIn,
  input  logic              acIn,
  input  logic              ovIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] extraOut,
  output logic              writeBack,
  output logic              cyOut,
  output logic              acOut,
  output logic              ovOut,
  output logic              parOut,
  output logic [3:0]        flagQ
);

  aluCtrlT   ctrl;
  logic [3:0] flagNext;

  acc_alu_ctrl u_ctrl (
    .opSel(opSel),
    .ctrl (ctrl)
  );

  acc_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .ctrl  (ctrl),
    .accIn (accIn),
    .opndIn(opndIn),
    .cyIn  (cyIn),
    .acIn  (acIn),
    .ovIn  (ovIn),
    .result(resultOut),
    .extra (extraOut),
    .cy    (cyOut),
    .ac    (acOut),
    .ov    (ovOut),
    .par   (parOut)
  );

  assign writeBack = ctrl.writeBack;
  assign flagNext  = {cyOut, acOut, ovOut, parOut};

  generate
    if (REG_FLAGS) begin : g_flagReg
      logic [3:0] flagRegQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         flagRegQ <= '0;
        else if (flagLoad) flagRegQ <= flagNext;
      end
      assign flagQ = flagRegQ;
    end else begin : g_flagComb
      assign flagQ = flagNext;
    end
  endgenerate

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit REG_FLAGS = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              flagLoad,
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] opndIn,
  input logic              cyIn,
  input logic              acIn,
  input logic              ovIn,
  input logic [DATA_W-1:0] resultOut,
  input logic [DATA_W-1:0] extraOut,
  input logic              writeBack,
  input logic              cyOut,
  input logic              acOut,
  input logic              ovOut,
  input logic              parOut,
  input logic [3:0]        flagQ
);

  localparam int W2 = 2 * DATA_W;

  AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_MUL) |-> ({extraOut, resultOut} == W2'(accIn) * W2'(opndIn))); // R9

  AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_MUL) |-> (!cyOut && (ovOut == (extraOut != '0)))); // R9

  AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_DIV && opndIn != '0) |->
      ((W2'(resultOut) * W2'(opndIn) + W2'(extraOut) == W2'(accIn)) &&
       (extraOut < opndIn) && !ovOut && !cyOut)); // R10

  AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_DIV && opndIn == '0) |->
      (ovOut && !cyOut && (&resultOut) && (extraOut == accIn))); // R10

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_CMP) |-> !writeBack); // R6

  AST_OTHER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opSel != OP_CMP) |-> writeBack); // R6

  AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= OP_INC && opSel <= OP_CPL) |->
      (cyOut == cyIn && acOut == acIn && ovOut == ovIn)); // R7

  AST_EXTRA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opSel < OP_MUL) |-> (extraOut == '0)); // R12

  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    parOut == !($countones(resultOut) % 2)); // R4

  generate
    if (REG_FLAGS) begin : g_regChk
      AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        flagLoad |=> (flagQ == $past({cyOut, acOut, ovOut, parOut}))); // R11

      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !flagLoad |=> $stable(flagQ)); // R11
    end
  endgenerate

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .REG_FLAGS(REG_FLAGS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .flagLoad (flagLoad),
  .opSel    (opSel),
  .accIn    (accIn),
  .opndIn   (opndIn),
  .cyIn     (cyIn),
  .acIn     (acIn),
  .ovIn     (ovIn),
  .resultOut(resultOut),
  .extraOut (extraOut),
  .writeBack(writeBack),
  .cyOut    (cyOut),
  .acOut    (acOut),
  .ovOut    (ovOut),
  .parOut   (parOut),
  .flagQ    (flagQ)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       flagLoad = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] accIn = '0;
  logic [7:0] opndIn = '0;
  logic       cyIn = 1'b0;
  logic       acIn = 1'b0;
  logic       ovIn = 1'b0;
  logic [7:0] resultOut;
  logic [7:0] extraOut;
  logic       writeBack;
  logic       cyOut;
  logic       acOut;
  logic       ovOut;
  logic       parOut;
  logic [3:0] flagQ;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  acc_alu #(.DATA_W(8), .REG_FLAGS(1'b1)) dut (
    .clk(clk), .rstN(rstN), .flagLoad(flagLoad), .opSel(opSel),
    .accIn(accIn), .opndIn(opndIn), .cyIn(cyIn), .acIn(acIn), .ovIn(ovIn),
    .resultOut(resultOut), .extraOut(extraOut), .writeBack(writeBack),
    .cyOut(cyOut), .acOut(acOut), .ovOut(ovOut), .parOut(parOut), .flagQ(flagQ)
  );

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       ci;
    logic       ai;
    logic       oi;
    logic [7:0] res;
    logic [7:0] ext;
    logic       co;
    logic       ao;
    logic       oo;
    logic       wb;
    logic [3:0] req;
  } vecT;

  localparam int NVEC = 23;
  localparam vecT VECS [NVEC] = '{
    '{4'd0,  8'h3A, 8'h2C, 1'b0, 1'b0, 1'b0, 8'h66, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 add nibble carry
    '{4'd0,  8'h80, 8'h80, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 carry and overflow
    '{4'd0,  8'h7F, 8'h01, 1'b1, 1'b0, 1'b0, 8'h80, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 overflow no carry
    '{4'd1,  8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1},  // R1 add with carry
    '{4'd2,  8'h50, 8'h20, 1'b1, 1'b0, 1'b1, 8'h2F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 borrow-in, nibble borrow
    '{4'd2,  8'h10, 8'h20, 1'b0, 1'b1, 1'b1, 8'hF0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 borrow out
    '{4'd2,  8'h80, 8'h01, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 signed sub overflow
    '{4'd13, 8'h33, 8'h33, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 equal compare
    '{4'd13, 8'h05, 8'h06, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 less-than compare
    '{4'd3,  8'hFF, 8'h55, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 increment wraps
    '{4'd4,  8'h00, 8'h55, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 decrement wraps
    '{4'd5,  8'hF0, 8'h3C, 1'b1, 1'b1, 1'b1, 8'h30, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 and
    '{4'd6,  8'hA0, 8'h05, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 or
    '{4'd7,  8'hFF, 8'h0F, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 xor
    '{4'd8,  8'h5A, 8'h00, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 complement
    '{4'd9,  8'h81, 8'h00, 1'b0, 1'b1, 1'b1, 8'h03, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 rotate left
    '{4'd10, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 rotate right
    '{4'd11, 8'h80, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 rotate left thru carry
    '{4'd12, 8'h02, 8'h00, 1'b1, 1'b1, 1'b0, 8'h81, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 rotate right thru carry
    '{4'd14, 8'h10, 8'h10, 1'b1, 1'b1, 1'b0, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 product above 255
    '{4'd14, 8'h0C, 8'h0A, 1'b1, 1'b0, 1'b1, 8'h78, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 small product
    '{4'd15, 8'hFB, 8'h12, 1'b1, 1'b1, 1'b1, 8'h0D, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 4'd10}, // R10 divide with remainder
    '{4'd15, 8'h42, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h42, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10}  // R10 zero divisor
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "flagQ in reset", {4'b0, flagQ}, 8'h00);
    rstN = 1'b1;

    // table walk; inputs change at negedge, combinational outputs sampled 1 ns later
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      opSel = VECS[i].op; accIn = VECS[i].a; opndIn = VECS[i].b;
      cyIn = VECS[i].ci; acIn = VECS[i].ai; ovIn = VECS[i].oi;
      #1;
      chk($sformatf("R%0d", VECS[i].req), "result", resultOut, VECS[i].res);
      chk($sformatf("R%0d", VECS[i].req), "cy", {7'b0, cyOut}, {7'b0, VECS[i].co});
      chk($sformatf("R%0d", VECS[i].req), "ac", {7'b0, acOut}, {7'b0, VECS[i].ao});
      chk($sformatf("R%0d", VECS[i].req), "ov", {7'b0, ovOut}, {7'b0, VECS[i].oo});
      chk("R6", "writeBack", {7'b0, writeBack}, {7'b0, VECS[i].wb});
      chk("R12", "extra", extraOut, VECS[i].ext);
      chk("R4", "parity", {7'b0, parOut}, {7'b0, ~^VECS[i].res});
    end

    // R11: load flags from 0x80+0x80 -> CY=1 AC=0 OV=1 P=1
    @(negedge clk);
    opSel = 4'd0; accIn = 8'h80; opndIn = 8'h80; cyIn = 1'b0; acIn = 1'b0; ovIn = 1'b0;
    flagLoad = 1'b1;
    @(negedge clk);
    flagLoad = 1'b0;
    chk("R11", "flagQ after load", {4'b0, flagQ}, 8'h0B);

    // R11: no load -> hold despite different flags (0x01+0x01 -> P=0, all else 0)
    accIn = 8'h01; opndIn = 8'h01;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "flagQ holds", {4'b0, flagQ}, 8'h0B);

    // R11: load the new flags
    flagLoad = 1'b1;
    @(negedge clk);
    flagLoad = 1'b0;
    chk("R11", "flagQ reload", {4'b0, flagQ}, 8'h00);

    // R11: reset clears after a load of non-zero flags
    opSel = 4'd15; accIn = 8'h07; opndIn = 8'h00;  // OV=1, q=FF -> P=1
    flagLoad = 1'b1;
    @(negedge clk);
    flagLoad = 1'b0;
    chk("R11", "flagQ div zero load", {4'b0, flagQ}, 8'h03);
    rstN = 1'b0;
    #1;
    chk("R11", "flagQ cleared by reset", {4'b0, flagQ}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule